// File: doc/BRIEF.md
# Ethernet Transmit Word-to-Byte Serializer

This block sits between a user application that writes Ethernet frames as 32-bit words and a byte-wide media interface that runs at one byte per clock. Each accepted word is split into its four bytes, most significant byte first. On the final word of a frame, the bytes that the empty field marks as unused are dropped. A frame starts only on a word flagged as start of packet. Words that arrive outside a frame are thrown away.

For each frame the application chooses one of two endings. In the first, the block computes a CRC-32 frame check sequence over the emitted bytes and appends it. In the second, the frame already carries its own check sequence and is passed through unchanged. A frame that the application marks bad is still sent, with the byte-side error flag set on its final byte. If the application stops presenting words partway through a frame, the block cuts the frame short and flags the last byte it sends as an error. It then ignores further words until the next start of packet.

Top module: `eth_tx_serializer`

## Requirements
- R1: Bytes of an accepted word leave on `gm_data` with `gm_en` high, one per clock, in the order bits 31:24, 23:16, 15:8, 7:0. The first byte of a frame appears on the ports two clock edges after the edge that accepts its start-of-packet word.
- R2: On the word that carries `tx_eop`, `tx_empty` gives the number of unused trailing bytes: 0 sends all four, 1 drops bits 7:0, 2 drops bits 15:0, 3 drops bits 23:0. On other words `tx_empty` is ignored.
- R3: While no frame is in progress, an accepted word without `tx_sop` produces no output byte, and `tx_ready` stays high.
- R4: When `tx_fcs_fwd` is 0 on the end-of-packet word, four check bytes follow the last data byte with no gap. The check value is CRC-32 with the reflected polynomial 0xEDB88320, started at all ones and complemented at the end, and its least significant byte is sent first.
- R5: When `tx_fcs_fwd` is 1 on the end-of-packet word, the frame ends after its last data byte and no extra bytes are added.
- R6: `tx_err` given with the end-of-packet word sets `gm_er` on the final byte of the frame only: the last check byte if one is appended, otherwise the last data byte. `gm_er` is never high while `gm_en` is low.
- R7: If `tx_valid` is low while the last byte of a word that is not the end of a frame is being sent, that byte carries `gm_er`. `gm_en` falls after it, and later words without `tx_sop` are discarded.
- R8: `tx_ready` is low right after a frame word is accepted and throughout the check bytes. Within a frame that is fed without pause, `gm_en` stays high from the first byte to the last.
- R9: After reset `gm_en` and `gm_er` are low and `tx_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_valid | input | 1 | Input word present |
| tx_data | input | 32 | Input word, first byte in bits 31:24 |
| tx_empty | input | 2 | Unused trailing bytes of the end-of-packet word |
| tx_sop | input | 1 | Word opens a frame |
| tx_eop | input | 1 | Word closes a frame |
| tx_err | input | 1 | Frame is bad (sampled with end of packet) |
| tx_fcs_fwd | input | 1 | 1: frame carries its own check sequence; 0: append CRC |
| tx_ready | output | 1 | Word is taken on this edge if valid |
| gm_data | output | 8 | Output byte |
| gm_en | output | 1 | Output byte is valid |
| gm_er | output | 1 | Output byte is marked in error |

## Verification
The first byte of a frame is due two clock edges after its start-of-packet word is accepted. Each following byte, including the four check bytes, is due exactly one edge after the one before, and the error flag is due on the same cycle as the byte it marks. The bench drives inputs and samples outputs on the falling edge. The driver records the expected cycle of each first byte and queues every expected byte with its error flag. The monitor pops one entry for each cycle in which `gm_en` is high, checks the first byte's cycle, and reports any gap inside a frame and any byte that appears when nothing is expected.

// File: rtl/eth_tx_pkg.sv
package eth_tx_pkg;

  localparam logic [31:0] CRC_POLY_REFL = 32'hEDB8_8320;
  localparam logic [31:0] CRC_SEED      = 32'hFFFF_FFFF;
  localparam int unsigned FCS_BYTES     = 4;

  // one byte through a reflected CRC-32 register, low bit first
  function automatic logic [31:0] crc32_step(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c ^ {24'd0, b};
    for (int i = 0; i < 8; i++) begin
      r = r[0] ? ((r >> 1) ^ CRC_POLY_REFL) : (r >> 1);
    end
    return r;
  endfunction

endpackage

// File: rtl/eth_tx_crc32.sv
module eth_tx_crc32
  import eth_tx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        init_i,
  input  logic        upd_i,
  input  logic [7:0]  byte_i,
  output logic [31:0] crc_o
);

  logic [31:0] crc_q, crc_d;
  logic        crc_en;

  assign crc_en = init_i | upd_i;

  always_comb begin
    crc_d = crc_q;
    if (init_i)     crc_d = CRC_SEED;
    else if (upd_i) crc_d = crc32_step(crc_q, byte_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      crc_q <= CRC_SEED;
    else if (crc_en) crc_q <= crc_d;
  end

  assign crc_o = crc_q;

  // R4
  crc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !init_i && !upd_i |=> $stable(crc_o));

endmodule

// File: rtl/eth_tx_word_buf.sv
module eth_tx_word_buf #(
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 8,
  localparam int unsigned DW    = LANES * LANE_W,
  localparam int unsigned IW    = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [DW-1:0]     word_i,
  input  logic [IW-1:0]     last_idx_i,
  output logic              vld_o,
  output logic [LANE_W-1:0] byte_o,
  output logic              last_o
);

  logic [DW-1:0]     word_q;
  logic [IW-1:0]     idx_q, idx_d, lim_q;
  logic              vld_q, vld_d;
  logic [LANE_W-1:0] lane [LANES];

  // first lane on the wire is the most significant one
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane[g] = word_q[DW-1-g*LANE_W -: LANE_W];
  end

  assign byte_o = lane[idx_q];
  assign last_o = vld_q && (idx_q == lim_q);
  assign vld_o  = vld_q;

  always_comb begin
    vld_d = vld_q;
    idx_d = idx_q;
    if (load_i) begin
      vld_d = 1'b1;
      idx_d = '0;
    end else if (vld_q) begin
      if (idx_q == lim_q) vld_d = 1'b0;
      else                idx_d = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      idx_q <= '0;
    end else begin
      vld_q <= vld_d;
      idx_q <= idx_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      lim_q  <= '0;
    end else if (load_i) begin
      word_q <= word_i;
      lim_q  <= last_idx_i;
    end
  end

  // R2
  idx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |-> idx_q <= lim_q);

  // R8
  no_overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |-> (!vld_q || last_o));

endmodule

// File: rtl/eth_tx_serializer.sv
module eth_tx_serializer
  import eth_tx_pkg::*;
#(
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 8,
  localparam int unsigned DW    = LANES * LANE_W,
  localparam int unsigned EW    = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int unsigned FIW   = $clog2(FCS_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_valid,
  input  logic [DW-1:0]     tx_data,
  input  logic [EW-1:0]     tx_empty,
  input  logic              tx_sop,
  input  logic              tx_eop,
  input  logic              tx_err,
  input  logic              tx_fcs_fwd,
  output logic              tx_ready,
  output logic [LANE_W-1:0] gm_data,
  output logic              gm_en,
  output logic              gm_er
);

  logic              buf_vld, buf_last;
  logic [LANE_W-1:0] buf_byte;
  logic [EW-1:0]     last_idx_in;
  logic              accept, load, trunc, data_end;
  logic              eop_q, err_q, fwd_q;
  logic              fcs_act_q, fcs_act_d, fcs_err_q, fcs_err_d;
  logic [FIW-1:0]    fcs_idx_q, fcs_idx_d;
  logic [31:0]       crc_cur, crc_fin;
  logic [7:0]        fcs_byte;
  logic [LANE_W-1:0] out_data_q, out_data_d;
  logic              out_en_q, out_en_d, out_er_q, out_er_d;

  assign last_idx_in = tx_eop ? (EW'(LANES - 1) - tx_empty) : EW'(LANES - 1);

  assign tx_ready = !fcs_act_q && (!buf_vld || (buf_last && !eop_q));
  assign accept   = tx_valid && tx_ready;
  assign load     = accept && (buf_vld || tx_sop);
  assign trunc    = buf_last && !eop_q && !tx_valid;
  assign data_end = buf_last && eop_q;

  eth_tx_word_buf #(.LANES(LANES), .LANE_W(LANE_W)) i_word_buf (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (load),
    .word_i     (tx_data),
    .last_idx_i (last_idx_in),
    .vld_o      (buf_vld),
    .byte_o     (buf_byte),
    .last_o     (buf_last)
  );

  eth_tx_crc32 i_crc (
    .clk    (clk),
    .rst_n  (rst_n),
    .init_i (load && !buf_vld),
    .upd_i  (buf_vld),
    .byte_i (buf_byte[7:0]),
    .crc_o  (crc_cur)
  );

  assign crc_fin  = ~crc_cur;
  assign fcs_byte = crc_fin[{fcs_idx_q, 3'b000} +: 8];

  // per-word flags, enabled by load
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eop_q <= 1'b0;
      err_q <= 1'b0;
      fwd_q <= 1'b0;
    end else if (load) begin
      eop_q <= tx_eop;
      err_q <= tx_eop && tx_err;
      fwd_q <= tx_fcs_fwd;
    end
  end

  // check-sequence phase
  always_comb begin
    fcs_act_d = fcs_act_q;
    fcs_idx_d = fcs_idx_q;
    fcs_err_d = fcs_err_q;
    if (fcs_act_q) begin
      fcs_idx_d = fcs_idx_q + 1'b1;
      if (fcs_idx_q == FIW'(FCS_BYTES - 1)) fcs_act_d = 1'b0;
    end else if (data_end && !fwd_q) begin
      fcs_act_d = 1'b1;
      fcs_idx_d = '0;
      fcs_err_d = err_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fcs_act_q <= 1'b0;
      fcs_idx_q <= '0;
      fcs_err_q <= 1'b0;
    end else begin
      fcs_act_q <= fcs_act_d;
      fcs_idx_q <= fcs_idx_d;
      fcs_err_q <= fcs_err_d;
    end
  end

  // byte-side output register
  always_comb begin
    out_data_d = '0;
    out_en_d   = 1'b0;
    out_er_d   = 1'b0;
    if (buf_vld) begin
      out_data_d = buf_byte;
      out_en_d   = 1'b1;
      out_er_d   = trunc || (data_end && fwd_q && err_q);
    end else if (fcs_act_q) begin
      out_data_d = LANE_W'(fcs_byte);
      out_en_d   = 1'b1;
      out_er_d   = fcs_err_q && (fcs_idx_q == FIW'(FCS_BYTES - 1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_data_q <= '0;
      out_en_q   <= 1'b0;
      out_er_q   <= 1'b0;
    end else begin
      out_data_q <= out_data_d;
      out_en_q   <= out_en_d;
      out_er_q   <= out_er_d;
    end
  end

  assign gm_data = out_data_q;
  assign gm_en   = out_en_q;
  assign gm_er   = out_er_q;

  // R1
  first_byte_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && tx_sop && !buf_vld |-> ##2 gm_en);

  // R6
  er_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gm_er |-> gm_en);

  // R7
  trunc_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trunc |=> gm_en && gm_er);

  // R7
  trunc_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trunc |-> ##2 !gm_en);

  // R8
  fcs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fcs_act_q |-> !tx_ready);

  // R4
  fcs_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_end && !fwd_q |=> ##1 gm_en);

endmodule

// File: tb/test_eth_tx_serializer.sv
module test_eth_tx_serializer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tx_valid = 1'b0, tx_sop = 1'b0, tx_eop = 1'b0, tx_err = 1'b0, tx_fcs_fwd = 1'b0;
  logic [31:0] tx_data = '0;
  logic [1:0]  tx_empty = '0;
  logic        tx_ready, gm_en, gm_er;
  logic [7:0]  gm_data;

  always #4 clk = ~clk;

  eth_tx_serializer i_eth_tx_serializer (
    .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_empty(tx_empty), .tx_sop(tx_sop), .tx_eop(tx_eop), .tx_err(tx_err),
    .tx_fcs_fwd(tx_fcs_fwd), .tx_ready(tx_ready),
    .gm_data(gm_data), .gm_en(gm_en), .gm_er(gm_er)
  );

  int checks = 0, failures = 0, cyc = 0, exp_first_cyc = 0, unexpected = 0;
  logic [10:0] expq [$];   // {first, last, er, data}
  string       tagq [$];
  logic [10:0] e;
  string       t;
  bit          mon_in_frame = 1'b0;
  logic [7:0]  fr [0:127];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] ref_crc(input int n);
    logic [31:0] c;
    c = 32'hFFFF_FFFF;
    for (int i = 0; i < n; i++) begin
      c = c ^ {24'd0, fr[i]};
      for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
    end
    return ~c;
  endfunction

  task automatic push(input logic [7:0] d, input bit er, input bit first, input bit last, input string tag);
    expq.push_back({first, last, er, d});
    tagq.push_back(tag);
  endtask

  task automatic check(input bit ok, input string msg);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s", msg);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (gm_en) begin
        checks++;
        if (expq.size() == 0) begin
          unexpected++;
          failures++;
          $display("FAIL R3 stray byte: actual data=%h er=%b expected no byte", gm_data, gm_er);
        end else begin
          e = expq.pop_front();
          t = tagq.pop_front();
          if (gm_data !== e[7:0] || gm_er !== e[8]) begin
            failures++;
            $display("FAIL %s byte: actual data=%h er=%b expected data=%h er=%b", t, gm_data, gm_er, e[7:0], e[8]);
          end
          if (e[10]) begin
            checks++;
            if (cyc != exp_first_cyc) begin
              failures++;
              $display("FAIL R1 first byte cycle: actual %0d expected %0d", cyc, exp_first_cyc);
            end
          end
          mon_in_frame = !e[9];
        end
      end else if (mon_in_frame) begin
        checks++;
        failures++;
        $display("FAIL R8 gap inside frame: actual gm_en=0 expected 1");
        mon_in_frame = 1'b0;
      end
    end
  end

  task automatic fill(input int len, input int seed);
    for (int i = 0; i < len; i++) fr[i] = 8'(seed * 7 + i * 13 + 1);
  endtask

  // called at a falling edge; returns at a falling edge
  task automatic send_frame(input int len, input bit fwd, input bit err, input int trunc_words, input string tag);
    int nw, sendw, tot, idx;
    logic [31:0] crc;
    nw    = (len + 3) / 4;
    sendw = (trunc_words > 0) ? trunc_words : nw;
    if (trunc_words > 0) begin
      for (int i = 0; i < 4 * trunc_words; i++)
        push(fr[i], i == 4 * trunc_words - 1, i == 0, i == 4 * trunc_words - 1, "R7");
    end else begin
      tot = len + (fwd ? 0 : 4);
      for (int i = 0; i < len; i++) push(fr[i], err && i == tot - 1, i == 0, i == tot - 1, tag);
      if (!fwd) begin
        crc = ref_crc(len);
        for (int k = 0; k < 4; k++) push(crc[8*k +: 8], err && k == 3, 1'b0, k == 3, "R4");
      end
    end
    for (int w = 0; w < sendw; w++) begin
      for (int b = 0; b < 4; b++) begin
        idx = 4 * w + b;
        tx_data[31 - 8*b -: 8] = (idx < len) ? fr[idx] : 8'hEE;
      end
      tx_valid   = 1'b1;
      tx_sop     = (w == 0);
      tx_eop     = (trunc_words == 0) && (w == nw - 1);
      tx_empty   = tx_eop ? 2'(4 * nw - len) : 2'(w);
      tx_err     = err;
      tx_fcs_fwd = fwd;
      while (!tx_ready) @(negedge clk);
      @(negedge clk);
      if (w == 0) exp_first_cyc = cyc + 1;
      check(tx_ready === 1'b0, $sformatf("R8 ready after word %0d: actual %b expected 0", w, tx_ready));
    end
    tx_valid = 1'b0; tx_sop = 1'b0; tx_eop = 1'b0; tx_err = 1'b0;
    while (expq.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic send_stray(input int n);
    int u0;
    u0 = unexpected;
    for (int w = 0; w < n; w++) begin
      tx_data  = 32'hA5A5_0000 + 32'(w);
      tx_valid = 1'b1; tx_sop = 1'b0; tx_eop = (w == n - 1); tx_empty = 2'd1;
      check(tx_ready === 1'b1, $sformatf("R3 ready idle: actual %b expected 1", tx_ready));
      @(negedge clk);
    end
    tx_valid = 1'b0; tx_eop = 1'b0;
    repeat (8) @(negedge clk);
    check(unexpected == u0, $sformatf("R3 dropped words: actual stray bytes %0d expected 0", unexpected - u0));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog: actual hung run expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9
    check(tx_ready === 1'b1 && gm_en === 1'b0 && gm_er === 1'b0,
          $sformatf("R9 reset: actual ready=%b en=%b er=%b expected 1 0 0", tx_ready, gm_en, gm_er));

    // R4 known check value of the digits 1..9
    for (int i = 0; i < 9; i++) fr[i] = 8'h31 + 8'(i);
    check(ref_crc(9) == 32'hCBF4_3926, $sformatf("R4 reference crc: actual %h expected cbf43926", ref_crc(9)));
    send_frame(9, 1'b0, 1'b0, 0, "R4");

    // R2 every length modulo 4, with appended check sequence
    for (int l = 60; l < 64; l++) begin
      fill(l, l);
      send_frame(l, 1'b0, 1'b0, 0, "R2");
    end
    fill(1, 3);
    send_frame(1, 1'b0, 1'b0, 0, "R2");

    // R5 pass-through of application check sequence
    fill(14, 5);
    send_frame(14, 1'b1, 1'b0, 0, "R5");

    // R6 error flag with and without appended bytes
    fill(20, 9);
    send_frame(20, 1'b0, 1'b1, 0, "R6");
    fill(7, 11);
    send_frame(7, 1'b1, 1'b1, 0, "R6");

    // R3 words outside a frame
    send_stray(3);

    // R7 valid drops after three words, then stray words, then recovery
    fill(40, 13);
    send_frame(40, 1'b0, 1'b0, 3, "R7");
    send_stray(2);
    fill(5, 17);
    send_frame(5, 1'b0, 1'b0, 0, "R7");

    check(expq.size() == 0, $sformatf("R1 leftover expected bytes: actual %0d expected 0", expq.size()));
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule